// File: doc/BRIEF.md
# Binary-Field Montgomery Ladder Point Multiplier

This block computes the scalar multiple k·P of a point on a binary elliptic curve y² + xy = x³ + ax² + b over GF(2^M). It uses only the x-coordinate of the base point and runs the constant-time ladder in projective X/Z form, so no field inversion occurs inside the loop. A caller presents the scalar, the affine x of P and the curve constant b. When the run finishes, the block returns two projective points: (X1, Z1) represents k·P and (X2, Z2) represents (k+1)·P. Conversion back to affine form and recovery of y are left to downstream logic.

Each scalar bit below the top set bit drives one combined step of point addition and point doubling. Every step is executed on one single-cycle field unit. That unit has one multiplier, two squarers and XOR adders. The additions and squarings are folded into the same cycles as the multiplications, so a step takes six cycles, one for each of the six field products it needs. The scalar bit selects which register pair receives the sum and which pair receives the double. This selection is done by multiplexing only, so the timing does not depend on the key bits.

Operands enter on a valid/ready handshake. `in_ready` is high only while the block is idle. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. While a run is in progress, `in_ready` stays low and `in_valid` is ignored, which is the only back-pressure the block applies. Results come out on plain outputs together with a one-cycle `done` strobe.

Top module: `ecc_ladder_mult`

## Requirements
- R1: `in_ready` is high only when idle. Operands are captured only on an edge with `in_valid` and `in_ready` both high. An `in_valid` raised while busy has no effect on the run's results.
- R2: After reset, `in_ready` is 1 and `done` is 0.
- R3: Let p be the index of the highest set bit of the scalar, with p = 0 for scalars 0 and 1. `done` is first high in the cycle that follows the 6·p-th rising edge after the accepting edge. This holds for any values of the lower scalar bits.
- R4: `done` is high for exactly one cycle, and `in_ready` is high again in the next cycle.
- R5: The four outputs stay unchanged from `done` until the next request is accepted.
- R6: For a scalar k ≥ 2, Z1 is nonzero and X1 = x(kP)·Z1. This holds whenever no multiple jP with 1 ≤ j ≤ k+1 is the point at infinity or has x = 0. It holds for either value of the curve constant a.
- R7: Under the same condition as R6, Z2 is nonzero and X2 = x((k+1)P)·Z2.
- R8: For scalar 0, the outputs are X1 = 1, Z1 = 0, X2 = x and Z2 = 1.
- R9: For scalar 1, the outputs are X1 = x, Z1 = 1, X2 = x⁴ + b and Z2 = x².
- R10: Field elements are in polynomial basis, with bit i holding the coefficient of t^i. Reduction uses the modulus t^M + POLY. The default is the pentanomial t^163+t^7+t^6+t^3+1; the trinomial t^167+t^6+1 is the other supported instance. The small test field is t^7+t+1 (POLY = 7'h03).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request holds valid operands |
| in_ready | output | 1 | Block is idle and will take a request |
| in_scalar | input | M | Scalar k |
| in_x | input | M | Affine x of the base point, nonzero |
| in_b | input | M | Curve constant b, nonzero |
| done | output | 1 | One-cycle strobe, results valid |
| out_x1 | output | M | Projective X of k·P |
| out_z1 | output | M | Projective Z of k·P |
| out_x2 | output | M | Projective X of (k+1)·P |
| out_z2 | output | M | Projective Z of (k+1)·P |

## Verification
The bench runs over the 7-bit field with every nonzero x, two values of b and a spread of scalars. For two base points it sweeps all 128 scalars. Each result is compared with affine multiples computed by repeated point addition. A swapped add/double selection, a product issued in the wrong phase, or a squarer with the wrong reduction each show up as X ≠ x·Z on almost every scalar.

The latency check depends only on the top set bit. It therefore catches a loop that starts at the top bit instead of the one below it, or that skips the last bit. The scalars 0 and 1 run zero iterations and expose a wrong initial load. A request driven in the middle of a run shows whether busy-time requests corrupt the captured operands.

// File: rtl/ecc_ladder_pkg.sv
package ecc_ladder_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} lad_state_t;
  localparam int NPHASE = 6;
  localparam logic [2:0] PH_LAST = 3'(NPHASE - 1);
endpackage

// File: rtl/gf_mul.sv
module gf_mul #(
  parameter int M = 163,
  parameter logic [M-1:0] POLY = 'hC9
) (
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic [M-1:0] p
);
  logic [M-1:0] acc;
  // MSB-first shift-and-add, reducing after every shift
  always_comb begin
    acc = '0;
    for (int i = M - 1; i >= 0; i--) begin
      acc = {acc[M-2:0], 1'b0} ^ (acc[M-1] ? POLY : '0) ^ (b[i] ? a : '0);
    end
    p = acc;
  end
endmodule

// File: rtl/gf_sqr.sv
module gf_sqr #(
  parameter int M = 163,
  parameter logic [M-1:0] POLY = 'hC9
) (
  input  logic [M-1:0] a,
  output logic [M-1:0] s
);
  localparam int WW = 2 * M - 1;
  logic [WW-1:0] v;
  // Spread the coefficients to even positions, then fold the upper half down
  always_comb begin
    v = '0;
    for (int i = 0; i < M; i++) v[2*i] = a[i];
    for (int i = WW - 1; i >= M; i--) begin
      if (v[i]) v[i-M +: M] = v[i-M +: M] ^ POLY;
    end
    s = v[M-1:0];
  end
endmodule

// File: rtl/ecl_ladder_ctrl.sv
module ecl_ladder_ctrl
  import ecc_ladder_pkg::*;
#(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [IW-1:0] top_pos,
  output logic          in_ready,
  output logic          accept,
  output logic          run,
  output logic          done,
  output logic [2:0]    phase,
  output logic [IW-1:0] idx
);
  lad_state_t state;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign run      = (state == ST_RUN);
  assign done     = (state == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      phase <= '0;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          phase <= '0;
          if (top_pos == '0) state <= ST_FIN;
          else begin
            state <= ST_RUN;
            idx   <= top_pos - IW'(1);
          end
        end
        ST_RUN: begin
          if (phase == PH_LAST) begin
            phase <= '0;
            if (idx == '0) state <= ST_FIN;
            else idx <= idx - IW'(1);
          end else begin
            phase <= phase + 3'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> phase <= PH_LAST);
  assert_first_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && top_pos != '0) |=> (run && phase == '0));
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready);
endmodule

// File: rtl/ecc_ladder_mult.sv
module ecc_ladder_mult
  import ecc_ladder_pkg::*;
#(
  parameter int M = 163,
  parameter logic [M-1:0] POLY = 'hC9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [M-1:0] in_scalar,
  input  logic [M-1:0] in_x,
  input  logic [M-1:0] in_b,
  output logic         done,
  output logic [M-1:0] out_x1,
  output logic [M-1:0] out_z1,
  output logic [M-1:0] out_x2,
  output logic [M-1:0] out_z2
);
  localparam int IW = $clog2(M);
  localparam logic [M-1:0] ONE = {{(M-1){1'b0}}, 1'b1};

  logic          accept, run;
  logic [2:0]    phase;
  logic [IW-1:0] idx, top_pos;

  logic [M-1:0] k_reg, x_reg, b_reg;
  logic [M-1:0] p1x, p1z, p2x, p2z;
  logic [M-1:0] t1, t2, t3, t5, sx, sz, zan, xan;
  logic [M-1:0] xa, za, xd, zd;
  logic [M-1:0] mul_a, mul_b, mul_p, sq0_in, sq0_out, sq1_in, sq1_out;
  logic         sel;

  // index of highest set scalar bit (0 for scalars 0 and 1)
  always_comb begin
    top_pos = '0;
    for (int i = 1; i < M; i++) if (in_scalar[i]) top_pos = IW'(i);
  end

  ecl_ladder_ctrl #(.IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .top_pos(top_pos),
    .in_ready(in_ready), .accept(accept), .run(run), .done(done),
    .phase(phase), .idx(idx)
  );

  // key bit picks which pair is summed and which is doubled
  assign sel = k_reg[idx];
  assign xa  = sel ? p1x : p2x;
  assign za  = sel ? p1z : p2z;
  assign xd  = sel ? p2x : p1x;
  assign zd  = sel ? p2z : p1z;

  // operand routing per phase of the six-cycle step
  always_comb begin
    mul_a  = xa;
    mul_b  = zd;
    sq0_in = xd;
    sq1_in = zd;
    if (!run) begin
      sq0_in = in_x;
      sq1_in = sq0_out;
    end else begin
      case (phase)
        3'd0: begin mul_a = xa;    mul_b = zd;                      end
        3'd1: begin mul_a = xd;    mul_b = za;                      end
        3'd2: begin mul_a = t1;    mul_b = t2;      sq0_in = t1 ^ t2; end
        3'd3: begin mul_a = x_reg; mul_b = zan;                     end
        3'd4: begin mul_a = b_reg; mul_b = sq0_out; sq0_in = sz;    end
        3'd5: begin mul_a = sx;    mul_b = sz;      sq0_in = sx;    end
        default: ;
      endcase
    end
  end

  gf_mul #(.M(M), .POLY(POLY)) u_mul  (.a(mul_a), .b(mul_b), .p(mul_p));
  gf_sqr #(.M(M), .POLY(POLY)) u_sqr0 (.a(sq0_in), .s(sq0_out));
  gf_sqr #(.M(M), .POLY(POLY)) u_sqr1 (.a(sq1_in), .s(sq1_out));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_reg <= '0; x_reg <= '0; b_reg <= '0;
      p1x <= '0; p1z <= '0; p2x <= '0; p2z <= '0;
      t1 <= '0; t2 <= '0; t3 <= '0; t5 <= '0;
      sx <= '0; sz <= '0; zan <= '0; xan <= '0;
    end else if (accept) begin
      k_reg <= in_scalar;
      x_reg <= in_x;
      b_reg <= in_b;
      if (in_scalar == '0) begin
        p1x <= ONE;  p1z <= '0;
        p2x <= in_x; p2z <= ONE;
      end else begin
        p1x <= in_x;           p1z <= ONE;
        p2x <= sq1_out ^ in_b; p2z <= sq0_out;
      end
    end else if (run) begin
      case (phase)
        3'd0: begin t1 <= mul_p; sx <= sq0_out; sz <= sq1_out; end
        3'd1: t2 <= mul_p;
        3'd2: begin t3 <= mul_p; zan <= sq0_out; end
        3'd3: xan <= mul_p ^ t3;
        3'd4: t5 <= mul_p;
        3'd5: begin
          if (sel) begin
            p1x <= xan; p1z <= zan; p2x <= sq0_out ^ t5; p2z <= mul_p;
          end else begin
            p2x <= xan; p2z <= zan; p1x <= sq0_out ^ t5; p1z <= mul_p;
          end
        end
        default: ;
      endcase
    end
  end

  assign out_x1 = p1x;
  assign out_z1 = p1z;
  assign out_x2 = p2x;
  assign out_z2 = p2z;

  assert_busy_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> ($stable(k_reg) && $stable(x_reg) && $stable(b_reg)));
  assert_step_writeback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase != PH_LAST) |=> ($stable(p1x) && $stable(p1z) && $stable(p2x) && $stable(p2z)));
  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> ($stable(p1x) && $stable(p1z) && $stable(p2x) && $stable(p2z)));
endmodule

// File: tb/test_ecc_ladder_mult.sv
module test_ecc_ladder_mult;
  typedef logic [6:0] fe_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready, done;
  fe_t  in_scalar = '0, in_x = '0, in_b = '0;
  fe_t  out_x1, out_z1, out_x2, out_z2;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ecc_ladder_mult #(.M(7), .POLY(7'h03)) i_ecc_ladder_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_scalar(in_scalar), .in_x(in_x), .in_b(in_b), .done(done),
    .out_x1(out_x1), .out_z1(out_z1), .out_x2(out_x2), .out_z2(out_z2)
  );

  // ---- reference field arithmetic over t^7 + t + 1 ----
  function automatic fe_t fmul(fe_t a, fe_t b);
    fe_t r = '0;
    fe_t s = a;
    for (int i = 0; i < 7; i++) begin
      if (b[i]) r = r ^ s;
      s = {s[5:0], 1'b0} ^ (s[6] ? 7'h03 : 7'h00);
    end
    return r;
  endfunction

  function automatic fe_t fsq(fe_t a);
    return fmul(a, a);
  endfunction

  function automatic fe_t finv(fe_t a);
    fe_t r = 7'h01;
    fe_t s = a;
    for (int i = 1; i < 7; i++) begin
      s = fsq(s);
      r = fmul(r, s);
    end
    return r;
  endfunction

  fe_t cur_a;

  task automatic padd(input bit ia, input fe_t xa, input fe_t ya,
                      input bit ib, input fe_t xb, input fe_t yb,
                      output bit io, output fe_t xo, output fe_t yo);
    fe_t lam;
    io = 1'b0; xo = '0; yo = '0;
    if (ia) begin io = ib; xo = xb; yo = yb; end
    else if (ib) begin io = ia; xo = xa; yo = ya; end
    else if (xa == xb) begin
      if (ya != yb || xa == '0) io = 1'b1;
      else begin
        lam = xa ^ fmul(ya, finv(xa));
        xo = fsq(lam) ^ lam ^ cur_a;
        yo = fsq(xa) ^ fmul(lam ^ 7'h01, xo);
      end
    end else begin
      lam = fmul(ya ^ yb, finv(xa ^ xb));
      xo = fsq(lam) ^ lam ^ xa ^ xb ^ cur_a;
      yo = fmul(lam, xa ^ xo) ^ xo ^ ya;
    end
  endtask

  fe_t mx [0:255];
  int  lim;

  // pick a curve (a) holding x, then tabulate x(jP) until infinity or x = 0
  task automatic setup(input fe_t x, input fe_t b);
    fe_t py = '0;
    bit found = 1'b0;
    bit ri, ni;
    fe_t rx, ry, nx, ny;
    for (int av = 0; av < 2 && !found; av++) begin
      for (int yv = 0; yv < 128 && !found; yv++) begin
        if ((fsq(7'(yv)) ^ fmul(x, 7'(yv))) ==
            (fmul(fsq(x), x) ^ (av == 1 ? fsq(x) : 7'h00) ^ b)) begin
          found = 1'b1; py = 7'(yv); cur_a = 7'(av);
        end
      end
    end
    ri = 1'b1; rx = '0; ry = '0;
    lim = 256;
    for (int j = 1; j < 256; j++) begin
      padd(ri, rx, ry, 1'b0, x, py, ni, nx, ny);
      ri = ni; rx = nx; ry = ny;
      mx[j] = rx;
      if (ri || rx == '0) begin lim = j; break; end
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  fe_t c_x1, c_z1, c_x2, c_z2;

  task automatic run(input fe_t k, input fe_t x, input fe_t b, input bit inject);
    int cnt, p;
    p = 0;
    for (int i = 1; i < 7; i++) if (k[i]) p = i;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready when idle", int'(in_ready), 1);
    in_valid = 1'b1; in_scalar = k; in_x = x; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    cnt = 1;
    while (!done && cnt < 400) begin
      if (inject && cnt == 3) begin
        chk(in_ready == 1'b0, "R1 not ready while busy", int'(in_ready), 0);
        in_valid = 1'b1; in_scalar = ~k; in_x = x ^ 7'h11; in_b = b ^ 7'h22;
      end
      @(negedge clk);
      in_valid = 1'b0;
      cnt++;
    end
    chk(done == 1'b1 && cnt == 6 * p + 1, "R3 latency", cnt, 6 * p + 1);
    c_x1 = out_x1; c_z1 = out_z1; c_x2 = out_x2; c_z2 = out_z2;
    @(negedge clk);
    chk(done == 1'b0 && in_ready == 1'b1, "R4 single done pulse", int'({done, in_ready}), 1);
    @(negedge clk);
    chk(out_x1 == c_x1 && out_z1 == c_z1 && out_x2 == c_x2 && out_z2 == c_z2,
        "R5 outputs held", int'({out_x1, out_z1}), int'({c_x1, c_z1}));
  endtask

  task automatic verify(input fe_t k, input fe_t x, input fe_t b);
    if (k == 7'd0) begin
      chk(c_x1 == 7'h01 && c_z1 == 7'h00 && c_x2 == x && c_z2 == 7'h01, "R8 zero scalar",
          int'({c_x1, c_z1, c_x2, c_z2}), int'({7'h01, 7'h00, x, 7'h01}));
    end else if (k == 7'd1) begin
      chk(c_x1 == x && c_z1 == 7'h01 && c_x2 == (fsq(fsq(x)) ^ b) && c_z2 == fsq(x),
          "R9 unit scalar", int'({c_x1, c_z1, c_x2, c_z2}),
          int'({x, 7'h01, fsq(fsq(x)) ^ b, fsq(x)}));
    end else if (int'(k) + 1 < lim) begin
      chk(c_z1 != '0 && c_x1 == fmul(mx[k], c_z1), "R6 R10 kP",
          int'({c_x1, c_z1}), int'(fmul(mx[k], c_z1)));
      chk(c_z2 != '0 && c_x2 == fmul(mx[int'(k) + 1], c_z2), "R7 R10 (k+1)P",
          int'({c_x2, c_z2}), int'(fmul(mx[int'(k) + 1], c_z2)));
    end
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    fe_t bv, k, r1x, r1z, r2x, r2z;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && done == 1'b0, "R2 reset state", int'({in_ready, done}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && done == 1'b0, "R2 after release", int'({in_ready, done}), 2);

    // spread of scalars over all nonzero x, two curve constants
    for (int bi = 0; bi < 2; bi++) begin
      bv = (bi == 0) ? 7'h01 : 7'h5B;
      for (int xi = 1; xi < 128; xi++) begin
        setup(7'(xi), bv);
        for (int ki = 0; ki < 6; ki++) begin
          k = (ki < 4) ? 7'(ki) : 7'(xi * (ki * 29 + 3) + bi * 17);
          run(k, 7'(xi), bv, 1'b0);
          verify(k, 7'(xi), bv);
        end
      end
    end

    // every scalar for two base points
    setup(7'h05, 7'h01);
    for (int ki = 0; ki < 128; ki++) begin
      run(7'(ki), 7'h05, 7'h01, 1'b0);
      verify(7'(ki), 7'h05, 7'h01);
    end
    setup(7'h2A, 7'h5B);
    for (int ki = 0; ki < 128; ki++) begin
      run(7'(ki), 7'h2A, 7'h5B, 1'b0);
      verify(7'(ki), 7'h2A, 7'h5B);
    end

    // R1: a request raised mid-run must not disturb the result
    run(7'd77, 7'h05, 7'h01, 1'b0);
    r1x = c_x1; r1z = c_z1; r2x = c_x2; r2z = c_z2;
    run(7'd77, 7'h05, 7'h01, 1'b1);
    chk(c_x1 == r1x && c_z1 == r1z && c_x2 == r2x && c_z2 == r2z, "R1 busy request ignored",
        int'({c_x1, c_z1, c_x2, c_z2}), int'({r1x, r1z, r2x, r2z}));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule